// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit buses, called A and B, and moves data in either direction. Each direction has its own storage register, capture strobe, output enable and source select. The select chooses what each direction drives. It can drive the live value of the opposite bus, or it can drive the word held in that direction's register. A build-time parameter decides whether both data paths are true or inverted.

The buses are not modelled as tristate pins. Each bus has three signals: an external data input with a flag that says an outside driver is active, a data output, and an output enable. The block sees a bus as the external value whenever the external flag is set. When no outside driver is active, a small keeper register per bus holds the last value seen. When both directions are enabled in live mode and nobody else drives, the keepers freeze. The two buses then hold their last state, and the block does this without a combinational loop.

All state runs on one system clock. The capture inputs are level signals. The block detects their rising edge on that clock.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high `rst` clears both storage registers and both keepers to zero. In the first cycle after reset, a direction set to stored mode drives the polarity function of zero.
- R2: On the first clock edge where `cap_ab` is 1 and was 0 at the previous edge, the A-to-B register loads the value on bus A. Bus A is `a_ext` when `a_ext_on` is 1, otherwise the block's own A output when `a_oe` is 1, otherwise the A keeper. If `cap_ab` stays high on later edges, nothing more is loaded.
- R3: The B-to-A register behaves the same way, using `cap_ba` and bus B.
- R4: A capture happens whatever the values of the select and enable inputs are.
- R5: When `sel_ab` is 0 (live), `b_out` is the polarity function of the bus A value that the block sees. That value is `a_ext` while `a_ext_on` is 1, otherwise the A keeper. When `sel_ab` is 1 (stored), `b_out` is the polarity function of the A-to-B register. This path is combinational.
- R6: The B-to-A direction works the same way, using `sel_ba`, bus B and the B-to-A register, and drives `a_out`.
- R7: `b_oe` follows `en_ab`, which is active high. `a_oe` is the inverse of `en_ba_n`, which is active low.
- R8: With `INVERT`=1 every driven word is the bitwise complement of its source. With `INVERT`=0 every driven word equals its source.
- R9: A keeper loads `*_ext` on each clock edge where the external flag of its bus is 1. Otherwise it loads the block's own output for that bus if that output is enabled, and otherwise it keeps its value. A live path whose bus has no external driver therefore drives the last bus value.
- R10: In mutual mode (`en_ab`=1, `en_ba_n`=0, both selects 0) with neither external flag set, both keepers freeze. Both `a_out` and `b_out` stay constant from cycle to cycle.
- R11: When a select changes while its source is steady, the output goes straight from the old source to the new one with no third value. When the select falls, the output shows the live value in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_ext | input | 8 | Value from the outside driver on bus A |
| a_ext_on | input | 1 | Outside driver on bus A is active |
| a_out | output | 8 | Word the block drives onto bus A |
| a_oe | output | 1 | Block drives bus A |
| b_ext | input | 8 | Value from the outside driver on bus B |
| b_ext_on | input | 1 | Outside driver on bus B is active |
| b_out | output | 8 | Word the block drives onto bus B |
| b_oe | output | 1 | Block drives bus B |
| cap_ab | input | 1 | A-to-B capture strobe, rising edge loads |
| cap_ba | input | 1 | B-to-A capture strobe, rising edge loads |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| en_ab | input | 1 | A-to-B output enable, active high |
| en_ba_n | input | 1 | B-to-A output enable, active low |

## Verification
A capture into a register and a stored-mode read of that same register can fall in one cycle. The bench sets up this case by putting the A-to-B direction in stored mode. It then changes bus A and raises the capture strobe halfway through a clock period. It checks that `b_out` still shows the old stored word before the edge and shows the new one right after it. A second case is a select change while the source is steady. For this case the output is sampled several times within the cycle, and each sample must equal the old source or the new one.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Source choice for one direction of the transceiver
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

endpackage

// File: rtl/xcvr_capture.sv
// Storage register loaded on the rising edge of a level strobe, seen on clk
module xcvr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic strobe_q;
  logic load;

  assign load = strobe && !strobe_q;

  always_ff @(posedge clk) begin
    strobe_q <= strobe;
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/xcvr_keeper.sv
// Holds the last value of one bus; the external driver takes precedence
module xcvr_keeper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_on,
  input  logic [W-1:0] ext_d,
  input  logic         own_on,
  input  logic [W-1:0] own_d,
  input  logic         freeze,
  output logic [W-1:0] seen
);

  logic [W-1:0] hold;

  assign seen = ext_on ? ext_d : hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
    end else if (ext_on) begin
      hold <= ext_d;
    end else if (own_on && !freeze) begin
      hold <= own_d;
    end
  end

endmodule

// File: rtl/xcvr_path.sv
// Source mux and polarity stage for one direction
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  src_sel_e     sel,
  output logic [W-1:0] y
);

  logic [W-1:0] picked;

  assign picked = (sel == SRC_STORED) ? stored : live;

  generate
    if (INVERT) begin : g_inv
      assign y = ~picked;
    end else begin : g_true
      assign y = picked;
    end
  endgenerate

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_ext,
  input  logic         a_ext_on,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_ext,
  input  logic         b_ext_on,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         en_ab,
  input  logic         en_ba_n
);

  logic [W-1:0] a_seen, b_seen;
  logic [W-1:0] a_bus, b_bus;
  logic [W-1:0] reg_ab, reg_ba;
  logic         mutual;

  assign b_oe = en_ab;
  assign a_oe = !en_ba_n;

  // Both directions live and enabled: the keepers must not chase each other
  assign mutual = en_ab && !en_ba_n && !sel_ab && !sel_ba;

  // Full bus value as a capture source (no loop: outputs depend on keepers)
  assign a_bus = a_ext_on ? a_ext : (a_oe ? a_out : a_seen);
  assign b_bus = b_ext_on ? b_ext : (b_oe ? b_out : b_seen);

  xcvr_keeper #(.W(W)) u_keep_a (
    .clk(clk), .rst(rst),
    .ext_on(a_ext_on), .ext_d(a_ext),
    .own_on(a_oe), .own_d(a_out),
    .freeze(mutual), .seen(a_seen)
  );

  xcvr_keeper #(.W(W)) u_keep_b (
    .clk(clk), .rst(rst),
    .ext_on(b_ext_on), .ext_d(b_ext),
    .own_on(b_oe), .own_d(b_out),
    .freeze(mutual), .seen(b_seen)
  );

  xcvr_capture #(.W(W)) u_cap_ab (
    .clk(clk), .rst(rst), .strobe(cap_ab), .d(a_bus), .q(reg_ab)
  );

  xcvr_capture #(.W(W)) u_cap_ba (
    .clk(clk), .rst(rst), .strobe(cap_ba), .d(b_bus), .q(reg_ba)
  );

  xcvr_path #(.W(W), .INVERT(INVERT)) u_path_ab (
    .live(a_seen), .stored(reg_ab), .sel(src_sel_e'(sel_ab)), .y(b_out)
  );

  xcvr_path #(.W(W), .INVERT(INVERT)) u_path_ba (
    .live(b_seen), .stored(reg_ba), .sel(src_sel_e'(sel_ba)), .y(a_out)
  );

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W   = 8,
  parameter bit INV = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_ext,
  input logic         a_ext_on,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_ext,
  input logic         b_ext_on,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic         cap_ab,
  input logic         cap_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         en_ab,
  input logic         en_ba_n
);

  function automatic logic [W-1:0] pol(input logic [W-1:0] x);
    return INV ? ~x : x;
  endfunction

  logic quiet_mutual;
  assign quiet_mutual = en_ab && !en_ba_n && !sel_ab && !sel_ba &&
                        !a_ext_on && !b_ext_on && a_oe && b_oe;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && sel_ab) |-> (b_out == pol('0)));

  // R2
  cap_ab_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_ab && !$past(cap_ab) && a_ext_on) |=> (!sel_ab || b_out == pol($past(a_ext))));

  // R3
  cap_ba_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_ba && !$past(cap_ba) && b_ext_on) |=> (!sel_ba || a_out == pol($past(b_ext))));

  // R5
  live_ab_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_ab && a_ext_on) |-> (b_out == pol(a_ext)));

  // R6
  live_ba_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_ba && b_ext_on) |-> (a_out == pol(b_ext)));

  // R10
  mutual_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet_mutual && $past(quiet_mutual)) |-> ($stable(a_out) && $stable(b_out)));

  // R11
  sel_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sel_ab) && a_ext_on && $stable(a_ext)) |-> (b_out == pol(a_ext)));

endmodule

bind bus_xcvr_reg xcvr_chk #(.W(W), .INV(INVERT)) u_chk (
  .clk(clk), .rst(rst),
  .a_ext(a_ext), .a_ext_on(a_ext_on), .a_out(a_out), .a_oe(a_oe),
  .b_ext(b_ext), .b_ext_on(b_ext_on), .b_out(b_out), .b_oe(b_oe),
  .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .en_ab(en_ab), .en_ba_n(en_ba_n)
);

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst;
  logic [W-1:0] a_ext, b_ext;
  logic         a_ext_on, b_ext_on, cap_ab, cap_ba, sel_ab, sel_ba, en_ab, en_ba_n;
  logic [W-1:0] a_out0, b_out0, a_out1, b_out1;
  logic         a_oe0, b_oe0, a_oe1, b_oe1;

  int total = 0;
  int bad   = 0;

  bus_xcvr_reg #(.W(W), .INVERT(1'b0)) u0 (
    .clk(clk), .rst(rst), .a_ext(a_ext), .a_ext_on(a_ext_on), .a_out(a_out0), .a_oe(a_oe0),
    .b_ext(b_ext), .b_ext_on(b_ext_on), .b_out(b_out0), .b_oe(b_oe0),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n)
  );

  bus_xcvr_reg #(.W(W), .INVERT(1'b1)) u1 (
    .clk(clk), .rst(rst), .a_ext(a_ext), .a_ext_on(a_ext_on), .a_out(a_out1), .a_oe(a_oe1),
    .b_ext(b_ext), .b_ext_on(b_ext_on), .b_out(b_out1), .b_oe(b_oe1),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Both instances on the B side: u0 true, u1 inverted (R8)
  task automatic chk_b(string req, logic [W-1:0] v);
    check(req, b_out0, v);
    check({req, " R8"}, b_out1, ~v);
  endtask

  task automatic chk_a(string req, logic [W-1:0] v);
    check(req, a_out0, v);
    check({req, " R8"}, a_out1, ~v);
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    sel_ab = 1'b1; en_ab = 1'b1; sel_ba = 1'b1; en_ba_n = 1'b0;
    #1;
    chk_b("R1 stored A-to-B after reset", '0);
    chk_a("R1 stored B-to-A after reset", '0);
  endtask

  task automatic t_enable();
    en_ab = 1'b0; #1; check("R7 b_oe low", {7'd0, b_oe0}, 8'd0);
    en_ab = 1'b1; #1; check("R7 b_oe high", {7'd0, b_oe0}, 8'd1);
    en_ba_n = 1'b1; #1; check("R7 a_oe off", {7'd0, a_oe0}, 8'd0);
    en_ba_n = 1'b0; #1; check("R7 a_oe on", {7'd0, a_oe1}, 8'd1);
  endtask

  task automatic t_live();
    logic [W-1:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    a_ext_on = 1'b1; b_ext_on = 1'b0; sel_ab = 1'b0; en_ab = 1'b1; en_ba_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      a_ext = pats[i]; #1;
      chk_b("R5 live A-to-B", pats[i]);
    end
    a_ext_on = 1'b0; b_ext_on = 1'b1; en_ab = 1'b0; sel_ba = 1'b0; en_ba_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      b_ext = ~pats[i]; #1;
      chk_a("R6 live B-to-A", ~pats[i]);
    end
    step();
  endtask

  task automatic t_capture();
    // A-to-B with path disabled and in live mode while loading (R4)
    en_ab = 1'b0; sel_ab = 1'b0; en_ba_n = 1'b1; a_ext_on = 1'b1; b_ext_on = 1'b0;
    a_ext = 8'h3C; cap_ab = 1'b1;
    step();
    cap_ab = 1'b0; a_ext = 8'h99; sel_ab = 1'b1; en_ab = 1'b1; #1;
    chk_b("R2 R4 capture A-to-B", 8'h3C);
    // held strobe loads only once
    step();
    cap_ab = 1'b1; a_ext = 8'h11;
    step();
    a_ext = 8'h22;
    step();
    cap_ab = 1'b0; #1;
    chk_b("R2 held strobe single load", 8'h11);
    // B-to-A
    en_ab = 1'b0; a_ext_on = 1'b0; b_ext_on = 1'b1; en_ba_n = 1'b1; sel_ba = 1'b0;
    b_ext = 8'hE7; cap_ba = 1'b1;
    step();
    cap_ba = 1'b0; b_ext = 8'h00; sel_ba = 1'b1; en_ba_n = 1'b0; #1;
    chk_a("R3 R4 capture B-to-A", 8'hE7);
    step();
  endtask

  task automatic t_same_cycle();
    en_ba_n = 1'b1; b_ext_on = 1'b0; en_ab = 1'b1; sel_ab = 1'b1; a_ext_on = 1'b1;
    a_ext = 8'h5A; cap_ab = 1'b1; #1;
    chk_b("R2 stored word before capture edge", 8'h11);
    step();
    cap_ab = 1'b0; #1;
    chk_b("R2 stored word after capture edge", 8'h5A);
  endtask

  task automatic t_glitch();
    logic [W-1:0] s;
    a_ext = 8'h66; #1;
    chk_b("R11 stored before switch", 8'h5A);
    sel_ab = 1'b0;
    for (int i = 0; i < 5; i++) begin
      #1;
      s = b_out0;
      check("R11 only old or new source", s, (s == 8'h5A) ? 8'h5A : 8'h66);
    end
    chk_b("R11 settled on live", 8'h66);
    step();
  endtask

  task automatic t_keeper();
    en_ba_n = 1'b1; en_ab = 1'b1; sel_ab = 1'b0; a_ext_on = 1'b1; a_ext = 8'h77;
    step();
    a_ext_on = 1'b0; a_ext = 8'hFF; #1;
    chk_b("R9 keeper holds last A", 8'h77);
    step();
    chk_b("R9 keeper still holds", 8'h77);
  endtask

  task automatic t_mutual();
    a_ext_on = 1'b1; a_ext = 8'hC3; b_ext_on = 1'b0;
    en_ab = 1'b1; en_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
    step();
    en_ba_n = 1'b0; a_ext_on = 1'b0; a_ext = 8'h00;
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R10 u0 A held", a_out0, 8'hC3);
      check("R10 u1 A held", a_out1, 8'hC3);
      check("R10 u0 B held", b_out0, 8'hC3);
      check("R10 u1 B held", b_out1, 8'h3C);
      step();
    end
  endtask

  initial begin
    rst = 1'b1; a_ext = '0; b_ext = '0; a_ext_on = 1'b0; b_ext_on = 1'b0;
    cap_ab = 1'b0; cap_ba = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b0; en_ba_n = 1'b1;
    step(); step();
    rst = 1'b0;
    t_reset();
    t_enable();
    t_live();
    t_capture();
    t_same_cycle();
    t_glitch();
    t_keeper();
    t_mutual();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule